// File: doc/BRIEF.md
# Floating-point status and control register

This block is the single 32-bit status and control word of a floating-point unit. Software reads it and writes it as one word. The arithmetic datapath reaches it through three paths:

- It raises sticky exception flags with one-cycle set pulses.
- It reports compare outcomes, which land in the four condition bits at the top of the word.
- It receives the decoded controls: rounding mode, flush-to-zero, default-NaN, half-precision flush and the alternative half-precision format bit.

Only a few regions of a written word are stored in the main control field. Reserved and trap-enable positions always read as zero. The short-vector length and stride are held in their own small registers and merged back into the read word. The saturation summary bit is held the same way. It is the OR of one indication per saturating lane. A write loads lane 0 with the written bit and clears the other lanes.

All inputs are single-cycle control pulses or levels, with no back-pressure. The read port is combinational from the registered state. A write, a flag pulse or a compare is visible on the read port and on the control outputs from the cycle after the clock edge that captured it.

Top module: `fpcsr_top`

## Requirements
- R1: A software write keeps bits 31:28, 26:22 and 19 of the written word in the main field; these read back unchanged until the next write or compare.
- R2: The control outputs decode the stored word. `rmode_o` is bits 23:22, where 0 is nearest-even, 1 is toward +infinity, 2 is toward -infinity and 3 is toward zero. `ftz_o` is bit 24, `dnan_o` is bit 25, `ahp_o` is bit 26 and `fz16_o` is bit 19.
- R3: Sticky flag `flag_set_i[k]` for k = 0..4 sets bit k, and `flag_set_i[5]` sets bit 7. The bits are invalid, divide-by-zero, overflow, underflow, inexact and input-denormal, in that order. A set bit stays set until a software write.
- R4: In a cycle with a software write, the written word decides every stored bit. Flag pulses, saturation pulses and compare results in that cycle have no effect.
- R5: Bits 15:8, 6 and 5 always read as zero. This covers the trap enables in bits 12:8 and 15, and no write can set them.
- R6: The vector length is written from bits 18:16 and the stride from bits 21:20. Both read back in those positions.
- R7: Read bit 27 is 1 when any of the `SAT_LANES` saturation indications is set. A pulse on `sat_set_i[i]` sets indication i. A write loads indication 0 with written bit 27 and clears the others.
- R8: With parameter `HALF_EN` = 0, bit 19 is stored as 0 whatever is written, and `fz16_o` stays 0.
- R9: When `cmp_valid_i` is high without a write, bits 31:28 take the code for `cmp_kind_i`: 0 (equal) gives 4'b0110, 1 (less) gives 4'b1000, 2 (greater) gives 4'b0010 and 3 (unordered) gives 4'b0011.
- R10: Reset clears every stored bit, so the read word and all control outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write word |
| sw_rdata_o | output | 32 | Software read word (merged view) |
| flag_set_i | input | 6 | Sticky exception set pulses from the datapath |
| sat_set_i | input | SAT_LANES | Saturation indication set pulses, one per lane |
| cmp_valid_i | input | 1 | Compare result strobe |
| cmp_kind_i | input | 2 | Compare outcome: equal, less, greater, unordered |
| rmode_o | output | 2 | Rounding mode to the datapath |
| ftz_o | output | 1 | Flush-to-zero control |
| dnan_o | output | 1 | Default-NaN control |
| fz16_o | output | 1 | Half-precision flush-to-zero control |
| ahp_o | output | 1 | Alternative half-precision format control |

## Verification
All the state is visible on the read port. A wrong stored bit therefore shows in the word read one cycle after the edge that stored it. A corrupted control field also shows at once on the matching decoded output. A sticky flag that drops, or a saturation lane that is lost, shows only if no write comes in between. The stimulus therefore mixes long write-free stretches with pulses. It also drives writes, pulses and compares in the same cycle, so that a wrong priority shows as a mismatched bit in the next read.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int CSR_W     = 32;
  localparam int NUM_FLAGS = 6;
  localparam int CTL_W     = 5;   // bits 26:22
  localparam int LEN_W     = 3;
  localparam int STRIDE_W  = 2;
  localparam int NZCV_W    = 4;

  localparam logic [CSR_W-1:0] KEEP_MASK = 32'hF7C8_0000;

  typedef enum logic [1:0] {
    RM_NEAREST   = 2'd0,
    RM_PLUS_INF  = 2'd1,
    RM_MINUS_INF = 2'd2,
    RM_ZERO      = 2'd3
  } round_mode_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_LT = 2'd1,
    CMP_GT = 2'd2,
    CMP_UN = 2'd3
  } cmp_kind_e;

  function automatic logic [NZCV_W-1:0] cmp_to_nzcv(input logic [1:0] kind);
    case (cmp_kind_e'(kind))
      CMP_EQ:  return 4'b0110;
      CMP_LT:  return 4'b1000;
      CMP_GT:  return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction
endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [NZCV_W-1:0]   w_nzcv,
  input  logic [CTL_W-1:0]    w_ctl,
  input  logic                w_fz16,
  input  logic [LEN_W-1:0]    w_len,
  input  logic [STRIDE_W-1:0] w_stride,
  input  logic                cmp_valid,
  input  logic [1:0]          cmp_kind,
  output logic [NZCV_W-1:0]   nzcv_q,
  output logic [CTL_W-1:0]    ctl_q,
  output logic                fz16_q,
  output logic [LEN_W-1:0]    len_q,
  output logic [STRIDE_W-1:0] stride_q
);
  logic fz16_wr;

  generate
    if (HALF_EN) begin : g_half
      assign fz16_wr = w_fz16;
    end else begin : g_nohalf
      assign fz16_wr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzcv_q   <= '0;
      ctl_q    <= '0;
      fz16_q   <= 1'b0;
      len_q    <= '0;
      stride_q <= '0;
    end else if (wr_en) begin
      nzcv_q   <= w_nzcv;
      ctl_q    <= w_ctl;
      fz16_q   <= fz16_wr;
      len_q    <= w_len;
      stride_q <= w_stride;
    end else if (cmp_valid) begin
      nzcv_q   <= cmp_to_nzcv(cmp_kind);
    end
  end
endmodule

// File: rtl/fpcsr_sticky.sv
module fpcsr_sticky #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NF-1:0] w_flags,
  input  logic [NF-1:0] set_pulse,
  output logic [NF-1:0] flags_q
);
  generate
    for (genvar k = 0; k < NF; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flags_q[k] <= 1'b0;
        else if (wr_en)  flags_q[k] <= w_flags[k];
        else if (set_pulse[k]) flags_q[k] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/fpcsr_sat.sv
module fpcsr_sat #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             w_bit,
  input  logic [LANES-1:0] set_pulse,
  output logic             summary
);
  logic [LANES-1:0] lane_q;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic load_val;
      if (i == 0) begin : g_first
        assign load_val = w_bit;
      end else begin : g_rest
        assign load_val = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            lane_q[i] <= 1'b0;
        else if (wr_en)        lane_q[i] <= load_val;
        else if (set_pulse[i]) lane_q[i] <= 1'b1;
      end
    end
  endgenerate

  assign summary = |lane_q;
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
#(
  parameter bit HALF_EN   = 1'b1,
  parameter int SAT_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_wr_en_i,
  input  logic [31:0]          sw_wdata_i,
  output logic [31:0]          sw_rdata_o,
  input  logic [5:0]           flag_set_i,
  input  logic [SAT_LANES-1:0] sat_set_i,
  input  logic                 cmp_valid_i,
  input  logic [1:0]           cmp_kind_i,
  output logic [1:0]           rmode_o,
  output logic                 ftz_o,
  output logic                 dnan_o,
  output logic                 fz16_o,
  output logic                 ahp_o
);
  logic [NZCV_W-1:0]    nzcv_q;
  logic [CTL_W-1:0]     ctl_q;
  logic                 fz16_q;
  logic [LEN_W-1:0]     len_q;
  logic [STRIDE_W-1:0]  stride_q;
  logic [NUM_FLAGS-1:0] flags_q;
  logic                 qc;
  logic [9:0]           wdata_unused;

  // Positions with no storage behind them: trap enables and reserved bits.
  assign wdata_unused = {sw_wdata_i[15:8], sw_wdata_i[6:5]};

  fpcsr_ctrl #(.HALF_EN(HALF_EN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sw_wr_en_i),
    .w_nzcv    (sw_wdata_i[31:28]),
    .w_ctl     (sw_wdata_i[26:22]),
    .w_fz16    (sw_wdata_i[19]),
    .w_len     (sw_wdata_i[18:16]),
    .w_stride  (sw_wdata_i[21:20]),
    .cmp_valid (cmp_valid_i),
    .cmp_kind  (cmp_kind_i),
    .nzcv_q    (nzcv_q),
    .ctl_q     (ctl_q),
    .fz16_q    (fz16_q),
    .len_q     (len_q),
    .stride_q  (stride_q)
  );

  fpcsr_sticky #(.NF(NUM_FLAGS)) u_sticky (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sw_wr_en_i),
    .w_flags   ({sw_wdata_i[7], sw_wdata_i[4:0]}),
    .set_pulse (flag_set_i),
    .flags_q   (flags_q)
  );

  fpcsr_sat #(.LANES(SAT_LANES)) u_sat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sw_wr_en_i),
    .w_bit     (sw_wdata_i[27]),
    .set_pulse (sat_set_i),
    .summary   (qc)
  );

  always_comb begin
    sw_rdata_o        = '0;
    sw_rdata_o[31:28] = nzcv_q;
    sw_rdata_o[27]    = qc;
    sw_rdata_o[26:22] = ctl_q;
    sw_rdata_o[21:20] = stride_q;
    sw_rdata_o[19]    = fz16_q;
    sw_rdata_o[18:16] = len_q;
    sw_rdata_o[7]     = flags_q[5];
    sw_rdata_o[4:0]   = flags_q[4:0];
  end

  assign rmode_o = ctl_q[1:0];
  assign ftz_o   = ctl_q[2];
  assign dnan_o  = ctl_q[3];
  assign ahp_o   = ctl_q[4];
  assign fz16_o  = fz16_q;
endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk
  import fpcsr_pkg::*;
#(
  parameter int SAT_LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sw_wr_en_i,
  input logic [31:0]          sw_wdata_i,
  input logic [31:0]          sw_rdata_o,
  input logic [5:0]           flag_set_i,
  input logic [SAT_LANES-1:0] sat_set_i,
  input logic                 cmp_valid_i,
  input logic [1:0]           cmp_kind_i,
  input logic [1:0]           rmode_o,
  input logic                 ftz_o,
  input logic                 dnan_o,
  input logic                 fz16_o,
  input logic                 ahp_o
);
  AST_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en_i |=> (sw_rdata_o[26:22] == $past(sw_wdata_i[26:22]))); // R1

  AST_CTRL_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    {ahp_o, dnan_o, ftz_o, rmode_o} == sw_rdata_o[26:22]); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en_i |=> ((sw_rdata_o[7:0] & $past(sw_rdata_o[7:0])) == $past(sw_rdata_o[7:0]))); // R3

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en_i && flag_set_i[5]) |=> sw_rdata_o[7]); // R3

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en_i |=> (sw_rdata_o[31:27] == $past(sw_wdata_i[31:27]) &&
                    sw_rdata_o[4:0] == $past(sw_wdata_i[4:0]))); // R4

  AST_TRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata_o[15:8] == 8'h00) && (sw_rdata_o[6:5] == 2'b00)); // R5

  AST_VEC_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en_i |=> (sw_rdata_o[21:20] == $past(sw_wdata_i[21:20]) &&
                    sw_rdata_o[18:16] == $past(sw_wdata_i[18:16]))); // R6

  AST_SAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en_i && (|sat_set_i)) |=> sw_rdata_o[27]); // R7

  AST_CMP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i && !sw_wr_en_i) |=> (sw_rdata_o[31:28] == cmp_to_nzcv($past(cmp_kind_i)))); // R9

  AST_FZ16_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fz16_o == sw_rdata_o[19]); // R8
endmodule

bind fpcsr_top fpcsr_chk #(.SAT_LANES(SAT_LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_wr_en_i  (sw_wr_en_i),
  .sw_wdata_i  (sw_wdata_i),
  .sw_rdata_o  (sw_rdata_o),
  .flag_set_i  (flag_set_i),
  .sat_set_i   (sat_set_i),
  .cmp_valid_i (cmp_valid_i),
  .cmp_kind_i  (cmp_kind_i),
  .rmode_o     (rmode_o),
  .ftz_o       (ftz_o),
  .dnan_o      (dnan_o),
  .fz16_o      (fz16_o),
  .ahp_o       (ahp_o)
);

// File: tb/sim_fpcsr_top.sv
module sim_fpcsr_top;
  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [31:0]      wdata = '0;
  logic [5:0]       fset = '0;
  logic [LANES-1:0] sset = '0;
  logic             cmpv = 1'b0;
  logic [1:0]       cmpk = '0;

  logic [31:0] rdata, rdata1;
  logic [1:0]  rmode, rmode1;
  logic ftz, dnan, fz16, ahp, ftz1, dnan1, fz16_1, ahp1;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [31:0] m_main = '0;
  logic [2:0]  m_len = '0;
  logic [1:0]  m_str = '0;
  logic [31:0] m_flags = '0;
  logic        m_qc = 1'b0;

  always #5 clk = ~clk;

  fpcsr_top #(.HALF_EN(1'b1), .SAT_LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_wr_en_i(wr_en), .sw_wdata_i(wdata),
    .sw_rdata_o(rdata), .flag_set_i(fset), .sat_set_i(sset),
    .cmp_valid_i(cmpv), .cmp_kind_i(cmpk), .rmode_o(rmode), .ftz_o(ftz),
    .dnan_o(dnan), .fz16_o(fz16), .ahp_o(ahp)
  );

  fpcsr_top #(.HALF_EN(1'b0), .SAT_LANES(LANES)) u1 (
    .clk(clk), .rst_n(rst_n), .sw_wr_en_i(wr_en), .sw_wdata_i(wdata),
    .sw_rdata_o(rdata1), .flag_set_i(fset), .sat_set_i(sset),
    .cmp_valid_i(cmpv), .cmp_kind_i(cmpk), .rmode_o(rmode1), .ftz_o(ftz1),
    .dnan_o(dnan1), .fz16_o(fz16_1), .ahp_o(ahp1)
  );

  function automatic logic [3:0] exp_code(input logic [1:0] k);
    case (k)
      2'd0: return 4'b0110;
      2'd1: return 4'b1000;
      2'd2: return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic logic [31:0] flag_pos(input logic [5:0] f);
    return {24'h0, f[5], 2'b00, f[4:0]};
  endfunction

  function automatic logic [31:0] model_read();
    return m_main | {10'h0, m_str, 1'b0, m_len, 16'h0} | m_flags | {4'h0, m_qc, 27'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, update the model at the capture edge,
  // return at the next falling edge.
  task automatic cyc(input logic w, input logic [31:0] d, input logic [5:0] f,
                     input logic [LANES-1:0] s, input logic cv, input logic [1:0] ck);
    wr_en = w; wdata = d; fset = f; sset = s; cmpv = cv; cmpk = ck;
    @(posedge clk);
    if (w) begin
      m_main  = d & 32'hF7C8_0000;
      m_len   = d[18:16];
      m_str   = d[21:20];
      m_flags = d & 32'h0000_009F;
      m_qc    = d[27];
    end else begin
      if (cv) m_main[31:28] = exp_code(ck);
      m_flags = m_flags | flag_pos(f);
      m_qc    = m_qc | (|s);
    end
    @(negedge clk);
    wr_en = 1'b0; fset = '0; sset = '0; cmpv = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 read word", rdata, 32'h0);
    check("R10 controls", {27'h0, rmode, ftz, dnan, fz16, ahp}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", rdata, 32'h0);

    // R2: each rounding mode encoding and control bits
    for (int m = 0; m < 4; m++) begin
      cyc(1'b1, {5'h0, 1'b1, 1'b0, 1'b1, m[1:0], 22'h0}, '0, '0, 1'b0, 2'd0);
      check("R2 rmode", {30'h0, rmode}, m);
      check("R2 ahp/dnan/ftz", {29'h0, ahp, dnan, ftz}, 32'h5);
    end

    // R1 R5 R6 R7: write all ones
    cyc(1'b1, 32'hFFFF_FFFF, '0, '0, 1'b0, 2'd0);
    check("R1 all-ones readback", rdata, 32'hFFFF_009F);
    check("R5 trap bits zero", rdata & 32'h0000_FF60, 32'h0);
    check("R6 len/stride", {27'h0, rdata[21:20], rdata[18:16]}, 32'h1F);
    check("R7 qc loaded", {31'h0, rdata[27]}, 32'h1);
    check("R2 fz16 out", {31'h0, fz16}, 32'h1);
    check("R8 half disabled word", rdata1, 32'hFFF7_009F);
    check("R8 half disabled fz16", {31'h0, fz16_1}, 32'h0);

    // R4: write zero while every pulse is active
    cyc(1'b1, 32'h0, 6'h3F, {LANES{1'b1}}, 1'b1, 2'd1);
    check("R4 write wins", rdata, 32'h0);

    // R3: single flag sets its position and stays
    cyc(1'b0, 32'h0, 6'b100000, '0, 1'b0, 2'd0);
    check("R3 input-denormal bit7", rdata, 32'h80);
    cyc(1'b0, 32'h0, 6'b000100, '0, 1'b0, 2'd0);
    repeat (5) cyc(1'b0, 32'h0, '0, '0, 1'b0, 2'd0);
    check("R3 sticky hold", rdata, 32'h84);

    // R7: a non-zero lane sets summary; write clears
    cyc(1'b0, 32'h0, '0, 4'b0100, 1'b0, 2'd0);
    check("R7 lane2 summary", {31'h0, rdata[27]}, 32'h1);
    cyc(1'b1, 32'h0, '0, '0, 1'b0, 2'd0);
    check("R7 write clears lanes", {31'h0, rdata[27]}, 32'h0);

    // R9: each compare code
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 32'h0, '0, '0, 1'b1, k[1:0]);
      check("R9 compare code", {28'h0, rdata[31:28]}, {28'h0, exp_code(k[1:0])});
    end

    // Random mix, checked against the model (R1 R3 R4 R6 R7 R9)
    m_main = m_main; // model already in step
    for (int i = 0; i < 400; i++) begin
      logic w;
      logic [31:0] d;
      logic [5:0] f;
      logic [LANES-1:0] s;
      w = ($urandom % 5) == 0;
      d = $urandom;
      f = (($urandom % 3) == 0) ? 6'($urandom) & 6'($urandom) : 6'h0;
      s = (($urandom % 6) == 0) ? LANES'($urandom) : '0;
      cyc(w, d, f, s, ($urandom % 4) == 0, 2'($urandom));
      check("R1/R4 random word", rdata, model_read());
      check("R2 random rmode", {30'h0, rmode}, {30'h0, m_main[23:22]});
      check("R8 random bit19", {31'h0, rdata1[19]}, 32'h0);
    end

    summary();
    $finish;
  end
endmodule